// File: doc/BRIEF.md
# Lockable Instruction Cache Replacement Controller

This block controls line locking and victim selection for a set-associative instruction cache. The tag and data arrays sit outside it. Each set holds one lock bit per way and a round-robin pointer. When an ordinary miss arrives, the block picks a victim way that is not locked. It raises a fill request naming the set and the way, and it holds that request until the memory side reports that the fill is done.

Software pins a routine into the cache by issuing lock requests one line at a time, stepping the address by one line each time. If the tag lookup reports that the line is already resident, the block marks that way locked where it stands. Otherwise it fills a victim and then locks it. The block refuses any request that would leave a set with no replaceable way, and it reports that refusal with an error pulse.

A single global unlock command clears every lock bit in one cycle. It leaves the cached lines valid, so they take part in round-robin replacement again without being fetched a second time.

Top module: `icache_lock_ctrl`

## Requirements
- R1: The set index is taken from address bits [9:5]. Bits [4:0] (the byte within the 32-byte line) and bits [31:10] have no effect on which set is used.
- R2: After reset no way is locked, every pointer is 0, and busy, fill_req, lock_done and lock_err are all low. The first miss to any set therefore fills way 0.
- R3: On an accepted miss, fill_req rises on the next cycle. fill_way is then the first unlocked way found by searching upward from the set's pointer, wrapping at the last way. fill_set, fill_way and fill_lock stay stable until fill_done is sampled. After that the pointer becomes the filled way plus one, modulo the number of ways.
- R4: A way that is locked is never named as the fill victim.
- R5: A lock request that misses causes a fill with fill_lock = 1. On the edge where fill_done is sampled, that way becomes locked, and lock_done pulses high for one cycle.
- R6: A lock request that hits (lock_hit = 1) issues no fill. On the next cycle lock_done pulses and the way lock_hit_way is locked. If that way was already locked, nothing else changes. A lock request does not move the pointer unless it causes a fill.
- R7: A lock request is refused if it would lock the last unlocked way of its set. The refusal is a one-cycle lock_err pulse, with no fill and no change to any lock bit or pointer. lock_done and lock_err are never high together.
- R8: unlock_all clears every lock bit within one cycle. It issues no fill and leaves every pointer unchanged, so the lines that were locked become victims again in round-robin order.
- R9: Requests are accepted only while busy is low. Within one cycle, unlock_all takes priority over lock_valid, and lock_valid takes priority over miss_valid. Requests that lose, or that arrive while busy is high, are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Ordinary miss needing a line fill |
| miss_addr | input | ADDR_W | Miss address |
| lock_valid | input | 1 | Lock-line request |
| lock_addr | input | ADDR_W | Address of the line to lock |
| lock_hit | input | 1 | Tag lookup found the lock line resident |
| lock_hit_way | input | log2(WAYS) | Way in which the lock line is resident |
| unlock_all | input | 1 | Global unlock command |
| fill_done | input | 1 | Memory side has completed the pending fill |
| busy | output | 1 | A fill is outstanding and new requests are not accepted |
| fill_req | output | 1 | Fill request is pending |
| fill_set | output | log2(SETS) | Set to fill |
| fill_way | output | log2(WAYS) | Victim way to fill |
| fill_lock | output | 1 | The pending fill belongs to a lock request |
| lock_done | output | 1 | One-cycle pulse: the lock request succeeded |
| lock_err | output | 1 | One-cycle pulse: the lock request was refused |

## Verification
The bench builds the block with its default values: four ways, 32 sets and 32-byte lines. With four ways, a set fills up after three locks, so the refusal path, the single remaining victim and the pointer wrap are all reached within a few requests. Random traffic is aimed mostly at a small pool of sets. This lets locked lines face long runs of conflicting misses, and lets global unlocks arrive while pointers are at every position. The address bits outside the set index are randomized so that they are seen to have no effect.

// File: rtl/icl_pkg.sv
package icl_pkg;

    typedef enum logic {
        ST_IDLE,
        ST_FILL
    } icl_state_e;

    // Successor of a way index in round-robin order.
    function automatic int unsigned wrap_next(int unsigned v, int unsigned n);
        return (v + 1 >= n) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/icl_lock_table.sv
module icl_lock_table #(
    parameter int unsigned WAYS = 4,
    parameter int unsigned SETS = 32
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             clr_all,
    input  logic                             mark_en,
    input  logic [$clog2(SETS)-1:0]          mark_set,
    input  logic [$clog2(WAYS)-1:0]          mark_way,
    output logic [SETS-1:0][WAYS-1:0]        lock_q
);
    for (genvar s = 0; s < SETS; s++) begin : g_set
        always_ff @(posedge clk) begin
            if (rst || clr_all) begin
                lock_q[s] <= '0;
            end else if (mark_en && (mark_set == s)) begin
                lock_q[s][mark_way] <= 1'b1;
            end
        end

        // At least one way in every set stays replaceable.
        AST_KEEP_FREE: assert property (@(posedge clk) disable iff (rst)
            $countones(lock_q[s]) < WAYS); // R7
    end
endmodule

// File: rtl/icl_rr_ptr.sv
module icl_rr_ptr
    import icl_pkg::*;
#(
    parameter int unsigned WAYS = 4,
    parameter int unsigned SETS = 32
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 adv_en,
    input  logic [$clog2(SETS)-1:0]              adv_set,
    input  logic [$clog2(WAYS)-1:0]              adv_way,
    output logic [SETS-1:0][$clog2(WAYS)-1:0]    ptr_q
);
    localparam int unsigned WAY_W = $clog2(WAYS);

    for (genvar s = 0; s < SETS; s++) begin : g_set
        always_ff @(posedge clk) begin
            if (rst) begin
                ptr_q[s] <= '0;
            end else if (adv_en && (adv_set == s)) begin
                ptr_q[s] <= WAY_W'(wrap_next(int'(adv_way), WAYS));
            end
        end
    end
endmodule

// File: rtl/icl_victim.sv
module icl_victim #(
    parameter int unsigned WAYS = 4
) (
    input  logic [WAYS-1:0]               locks,
    input  logic [$clog2(WAYS)-1:0]       ptr,
    output logic [$clog2(WAYS)-1:0]       victim,
    output logic [$clog2(WAYS+1)-1:0]     lock_cnt
);
    localparam int unsigned WAY_W = $clog2(WAYS);
    localparam int unsigned CNT_W = $clog2(WAYS + 1);

    always_comb begin
        logic found;
        found  = 1'b0;
        victim = ptr;
        for (int i = 0; i < WAYS; i++) begin
            logic [WAY_W-1:0] cand;
            cand = WAY_W'((int'(ptr) + i) % WAYS);
            if (!found && !locks[cand]) begin
                victim = cand;
                found  = 1'b1;
            end
        end
    end

    always_comb begin
        lock_cnt = '0;
        for (int i = 0; i < WAYS; i++) begin
            lock_cnt = lock_cnt + CNT_W'(locks[i]);
        end
    end
endmodule

// File: rtl/icache_lock_ctrl.sv
module icache_lock_ctrl
    import icl_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned WAYS       = 4,
    parameter int unsigned SETS       = 32,
    parameter int unsigned LINE_BYTES = 32
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        miss_valid,
    input  logic [ADDR_W-1:0]           miss_addr,
    input  logic                        lock_valid,
    input  logic [ADDR_W-1:0]           lock_addr,
    input  logic                        lock_hit,
    input  logic [$clog2(WAYS)-1:0]     lock_hit_way,
    input  logic                        unlock_all,
    input  logic                        fill_done,
    output logic                        busy,
    output logic                        fill_req,
    output logic [$clog2(SETS)-1:0]     fill_set,
    output logic [$clog2(WAYS)-1:0]     fill_way,
    output logic                        fill_lock,
    output logic                        lock_done,
    output logic                        lock_err
);
    localparam int unsigned OFF_W = $clog2(LINE_BYTES);
    localparam int unsigned IDX_W = $clog2(SETS);
    localparam int unsigned WAY_W = $clog2(WAYS);
    localparam int unsigned CNT_W = $clog2(WAYS + 1);
    localparam int unsigned IDX_HI = OFF_W + IDX_W - 1;

    typedef struct packed {
        logic [IDX_W-1:0] set;
        logic [WAY_W-1:0] way;
        logic             for_lock;
    } fill_t;

    icl_state_e                   state_q;
    fill_t                        fill_q;
    logic                         done_q, err_q;
    logic [SETS-1:0][WAYS-1:0]    lock_q;
    logic [SETS-1:0][WAY_W-1:0]   ptr_q;

    logic [IDX_W-1:0] req_set;
    logic [WAYS-1:0]  req_locks;
    logic [WAY_W-1:0] vic_way;
    logic [CNT_W-1:0] lock_cnt;
    logic idle, set_full, hit_is_locked;
    logic take_unlock, take_lock, take_miss;
    logic lock_refuse, hit_mark, hit_ack, start_fill, complete;
    logic mark_en;
    logic [IDX_W-1:0] mark_set;
    logic [WAY_W-1:0] mark_way;

    logic [2*(ADDR_W-IDX_W)-1:0] unused_addr_bits;
    assign unused_addr_bits = {miss_addr[ADDR_W-1:IDX_HI+1], miss_addr[OFF_W-1:0],
                               lock_addr[ADDR_W-1:IDX_HI+1], lock_addr[OFF_W-1:0]};

    // Request decode: at most one request is taken, and only when idle.
    assign idle        = (state_q == ST_IDLE);
    assign take_unlock = idle && unlock_all;
    assign take_lock   = idle && !unlock_all && lock_valid;
    assign take_miss   = idle && !unlock_all && !lock_valid && miss_valid;

    assign req_set   = lock_valid ? lock_addr[OFF_W +: IDX_W] : miss_addr[OFF_W +: IDX_W];
    assign req_locks = lock_q[req_set];

    icl_victim #(.WAYS(WAYS)) u_victim (
        .locks    (req_locks),
        .ptr      (ptr_q[req_set]),
        .victim   (vic_way),
        .lock_cnt (lock_cnt)
    );

    assign set_full      = (lock_cnt == CNT_W'(WAYS - 1));
    assign hit_is_locked = req_locks[lock_hit_way];
    assign lock_refuse   = take_lock && !(lock_hit && hit_is_locked) && set_full;
    assign hit_mark      = take_lock && lock_hit && !hit_is_locked && !set_full;
    assign hit_ack       = take_lock && lock_hit && !lock_refuse;
    assign start_fill    = take_miss || (take_lock && !lock_hit && !set_full);
    assign complete      = (state_q == ST_FILL) && fill_done;

    // Lock bit updates: in place on a hit, or after a lock fill has completed.
    assign mark_en  = hit_mark || (complete && fill_q.for_lock);
    assign mark_set = complete ? fill_q.set : req_set;
    assign mark_way = complete ? fill_q.way : lock_hit_way;

    icl_lock_table #(.WAYS(WAYS), .SETS(SETS)) u_locks (
        .clk      (clk),
        .rst      (rst),
        .clr_all  (take_unlock),
        .mark_en  (mark_en),
        .mark_set (mark_set),
        .mark_way (mark_way),
        .lock_q   (lock_q)
    );

    icl_rr_ptr #(.WAYS(WAYS), .SETS(SETS)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .adv_en  (complete),
        .adv_set (fill_q.set),
        .adv_way (fill_q.way),
        .ptr_q   (ptr_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            fill_q  <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= hit_ack || (complete && fill_q.for_lock);
            err_q  <= lock_refuse;
            case (state_q)
                ST_IDLE: if (start_fill) begin
                    state_q <= ST_FILL;
                    fill_q  <= '{set: req_set, way: vic_way, for_lock: take_lock};
                end
                ST_FILL: if (fill_done) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy      = !idle;
    assign fill_req  = (state_q == ST_FILL);
    assign fill_set  = fill_q.set;
    assign fill_way  = fill_q.way;
    assign fill_lock = fill_q.for_lock;
    assign lock_done = done_q;
    assign lock_err  = err_q;

    AST_VICTIM_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
        fill_req |-> !lock_q[fill_set][fill_way]); // R4
    AST_FILL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (fill_req && !fill_done) |=> (fill_req && $stable(fill_way) && $stable(fill_set))); // R3
    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(lock_done && lock_err)); // R7
    AST_ERR_NO_FILL: assert property (@(posedge clk) disable iff (rst)
        lock_err |-> !fill_req); // R7
    AST_UNLOCK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (unlock_all && !busy) |=> (lock_q == '0)); // R8
endmodule

// File: tb/sim_icache_lock_ctrl.sv
module sim_icache_lock_ctrl;
    localparam int ADDR_W = 32;
    localparam int WAYS   = 4;
    localparam int SETS   = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic miss_valid = 1'b0, lock_valid = 1'b0, lock_hit = 1'b0;
    logic unlock_all = 1'b0, fill_done = 1'b0;
    logic [ADDR_W-1:0] miss_addr = '0, lock_addr = '0;
    logic [1:0] lock_hit_way = '0;
    logic busy, fill_req, fill_lock, lock_done, lock_err;
    logic [4:0] fill_set;
    logic [1:0] fill_way;

    int checks = 0;
    int errors = 0;
    bit m_lock [SETS][WAYS];
    int m_ptr  [SETS];

    always #2 clk = ~clk;

    icache_lock_ctrl #(.ADDR_W(ADDR_W), .WAYS(WAYS), .SETS(SETS), .LINE_BYTES(32)) u0 (
        .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_addr(miss_addr),
        .lock_valid(lock_valid), .lock_addr(lock_addr), .lock_hit(lock_hit),
        .lock_hit_way(lock_hit_way), .unlock_all(unlock_all), .fill_done(fill_done),
        .busy(busy), .fill_req(fill_req), .fill_set(fill_set), .fill_way(fill_way),
        .fill_lock(fill_lock), .lock_done(lock_done), .lock_err(lock_err)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_victim(int s);
        for (int i = 0; i < WAYS; i++) begin
            int w = (m_ptr[s] + i) % WAYS;
            if (!m_lock[s][w]) return w;
        end
        return -1;
    endfunction

    function automatic int lock_count(int s);
        int n = 0;
        for (int w = 0; w < WAYS; w++) n += int'(m_lock[s][w]);
        return n;
    endfunction

    // Random address whose bits [9:5] select set s.
    function automatic logic [31:0] mk_addr(int s);
        logic [31:0] a = $urandom();
        a[9:5] = 5'(s);
        return a;
    endfunction

    // Called at the negedge after the fill was accepted.
    task automatic wait_fill(int lat, int way, bit is_lock, string req);
        for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            chk({req, " fill held"}, int'(fill_req), 1);
            chk({req, " way held"}, int'(fill_way), way);
        end
        fill_done = 1'b1;
        @(negedge clk);
        fill_done = 1'b0;
        chk({req, " fill released"}, int'(fill_req), 0);
        chk({req, " lock_done after fill"}, int'(lock_done), int'(is_lock));
    endtask

    task automatic op_miss(int s, int lat);
        int v = exp_victim(s);
        @(negedge clk);
        miss_valid = 1'b1;
        miss_addr  = mk_addr(s);
        @(negedge clk);
        miss_valid = 1'b0;
        chk("R3 fill_req", int'(fill_req), 1);
        chk("R1 fill_set", int'(fill_set), s);
        chk("R4 R3 fill_way", int'(fill_way), v);
        chk("R3 fill_lock", int'(fill_lock), 0);
        wait_fill(lat, v, 1'b0, "R3");
        m_ptr[s] = (v + 1) % WAYS;
    endtask

    task automatic op_lock(int s, bit hit, int hw, int lat);
        bit full = (lock_count(s) == WAYS - 1);
        @(negedge clk);
        lock_valid   = 1'b1;
        lock_addr    = mk_addr(s);
        lock_hit     = hit;
        lock_hit_way = 2'(hw);
        @(negedge clk);
        lock_valid = 1'b0;
        lock_hit   = 1'b0;
        if (hit && m_lock[s][hw]) begin
            chk("R6 relock done", int'(lock_done), 1);
            chk("R6 relock no fill", int'(fill_req), 0);
        end else if (full) begin
            chk("R7 refuse err", int'(lock_err), 1);
            chk("R7 refuse no done", int'(lock_done), 0);
            chk("R7 refuse no fill", int'(fill_req), 0);
        end else if (hit) begin
            chk("R6 hit done", int'(lock_done), 1);
            chk("R6 hit no fill", int'(fill_req), 0);
            m_lock[s][hw] = 1'b1;
        end else begin
            int v = exp_victim(s);
            chk("R5 fill_req", int'(fill_req), 1);
            chk("R5 fill_lock", int'(fill_lock), 1);
            chk("R1 R5 fill_set", int'(fill_set), s);
            chk("R5 R4 fill_way", int'(fill_way), v);
            chk("R5 no early done", int'(lock_done), 0);
            wait_fill(lat, v, 1'b1, "R5");
            m_lock[s][v] = 1'b1;
            m_ptr[s] = (v + 1) % WAYS;
        end
    endtask

    task automatic op_unlock();
        @(negedge clk);
        unlock_all = 1'b1;
        @(negedge clk);
        unlock_all = 1'b0;
        chk("R8 unlock no fill", int'(fill_req), 0);
        chk("R8 unlock not busy", int'(busy), 0);
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) m_lock[s][w] = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1c0c4));
        for (int s = 0; s < SETS; s++) begin
            m_ptr[s] = 0;
            for (int w = 0; w < WAYS; w++) m_lock[s][w] = 1'b0;
        end
        repeat (3) @(negedge clk);
        chk("R2 reset busy", int'(busy), 0);
        chk("R2 reset fill_req", int'(fill_req), 0);
        chk("R2 reset lock_done", int'(lock_done), 0);
        chk("R2 reset lock_err", int'(lock_err), 0);
        rst = 1'b0;

        // R2: the first miss fills way 0
        op_miss(3, 0);
        // R3: round robin through all ways, with wrap
        for (int i = 0; i < 5; i++) op_miss(5, i % 3);

        // R5 / R7: lock three ways of set 7, then the fourth is refused
        for (int i = 0; i < 3; i++) op_lock(7, 1'b0, 0, 1);
        op_lock(7, 1'b0, 0, 0);
        op_lock(7, 1'b1, 3, 0);   // R7: a hit on the last free way is refused
        op_lock(7, 1'b1, 1, 0);   // R6: a hit on an already locked way is acked
        // R4: locked lines survive conflicting misses
        for (int i = 0; i < 8; i++) op_miss(7, i % 2);

        // R6: lock in place, then misses skip that way
        op_lock(9, 1'b1, 2, 0);
        for (int i = 0; i < 4; i++) op_miss(9, 0);

        // R9: requests during busy are dropped (including unlock)
        begin
            int v = exp_victim(11);
            @(negedge clk);
            miss_valid = 1'b1;
            miss_addr  = mk_addr(11);
            @(negedge clk);
            miss_valid = 1'b0;
            chk("R9 busy set", int'(busy), 1);
            unlock_all = 1'b1;
            lock_valid = 1'b1;
            lock_addr  = mk_addr(12);
            @(negedge clk);
            unlock_all = 1'b0;
            lock_valid = 1'b0;
            chk("R9 fill unaffected", int'(fill_way), v);
            wait_fill(0, v, 1'b0, "R9");
            m_ptr[11] = (v + 1) % WAYS;
            @(negedge clk);
            chk("R9 dropped while busy", int'(fill_req), 0);
        end
        op_miss(7, 0);   // R9: ways 0..2 of set 7 must still be locked
        op_miss(12, 0);  // R9: the dropped lock did not touch set 12

        // R8: unlock, then round robin resumes over every way
        op_unlock();
        for (int i = 0; i < 4; i++) op_miss(7, 0);
        op_lock(7, 1'b1, 0, 0);   // R8: line still valid, locked in place

        // R9: priority of unlock over lock over miss
        @(negedge clk);
        unlock_all = 1'b1;
        lock_valid = 1'b1; lock_addr = mk_addr(20); lock_hit = 1'b0;
        miss_valid = 1'b1; miss_addr = mk_addr(21);
        @(negedge clk);
        unlock_all = 1'b0; lock_valid = 1'b0; miss_valid = 1'b0;
        chk("R9 unlock wins no fill", int'(fill_req), 0);
        chk("R9 unlock wins no done", int'(lock_done), 0);
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) m_lock[s][w] = 1'b0;
        begin
            int v = exp_victim(20);
            @(negedge clk);
            lock_valid = 1'b1; lock_addr = mk_addr(20); lock_hit = 1'b0;
            miss_valid = 1'b1; miss_addr = mk_addr(21);
            @(negedge clk);
            lock_valid = 1'b0; miss_valid = 1'b0;
            chk("R9 lock wins set", int'(fill_set), 20);
            chk("R9 lock wins kind", int'(fill_lock), 1);
            wait_fill(1, v, 1'b1, "R9");
            m_lock[20][v] = 1'b1;
            m_ptr[20] = (v + 1) % WAYS;
        end
        op_miss(21, 0);   // R9: the losing miss was dropped, so the pointer is still 0

        // Constrained random traffic on a small pool of sets
        for (int n = 0; n < 2500; n++) begin
            int r   = $urandom_range(15, 0);
            int s   = ($urandom_range(3, 0) == 0) ? $urandom_range(SETS - 1, 0)
                                                  : $urandom_range(3, 0);
            int lat = $urandom_range(2, 0);
            if (r == 0)      op_unlock();
            else if (r < 6)  op_lock(s, 1'(($urandom() & 1)), $urandom_range(WAYS - 1, 0), lat);
            else             op_miss(s, lat);
        end

        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule